// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the register-side half of a single PS/2 keyboard or mouse port. A processor reaches it over a plain 32-bit register bus made of an address, separate read and write strobes, write data and read data. On the other side it exchanges whole bytes with a serial engine that does the bit-level PS/2 clock and data shifting. That engine is not part of this block. It hands over each received byte with a one-cycle strobe, and it takes each byte to send as a one-cycle pulse.

The block holds a received byte until software takes it, and raises a pending flag while a byte waits. The status word reports the pending flag and a parity bit. The parity bit is computed on the fly from the byte most recently handed to software. An interrupt line combines two enables from the control word. The receive enable is gated by the pending flag. The transmit enable asserts the line on its own, because the transmit side is always reported empty.

A clock-divisor word is kept for the serial engine. A read of the data word takes the waiting byte only when one is pending, and otherwise repeats the previous byte. The top 32 bytes of the address window return a fixed eight-byte identification sequence, one byte per word.

Top module: `ps2_regif`

## Requirements
- R1: Registers are selected by address bits above bit 1 (word index): index 0 control, 1 status, 2 data, 3 divisor, 4 interrupt status. With the default RDATA_REG=1, bus_rdata carries the addressed value from the clock edge that samples bus_rd until the next read.
- R2: The control and divisor words are read/write and return the full 32-bit value last written.
- R3: The status word has bit 6 always 1 (transmit empty) and bit 4 equal to the pending flag. Bits 5, 3, 1 and 0 read 0, as do bits 31:7.
- R4: Status bit 2 is the XOR of the eight bits of the byte most recently returned by a data read. It does not depend on a byte that is still waiting.
- R5: A data read returns the waiting byte and consumes it when a byte is pending. With no byte pending it returns the previous byte again. Bits 31:8 read 0.
- R6: A cycle with rx_valid high stores rx_byte and sets pending. If a consuming data read falls in the same cycle, the read returns the older byte, and the new byte stays pending.
- R7: irq equals (pending AND control bit 4) OR control bit 3. It follows a control write or a change of pending in the next cycle.
- R8: The interrupt status word reads 2 + pending: bit 1 is always set and bit 0 is the pending flag.
- R9: A write to the data word produces, in the next cycle, a one-cycle tx_valid pulse with tx_byte equal to write data bits 7:0. tx_valid never rises otherwise.
- R10: Reads in the top 32 bytes of the window (0xFE0 to 0xFFF by default) return the identification byte at index (address - 0xFE0) >> 2. The sequence is 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads of any other address return 0. Writes to the status word, to the interrupt status word or to any unmapped address change no state and issue no transmit.
- R12: Synchronous reset clears control, divisor, the pending flag, both stored bytes, tx_valid and bus_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| rx_valid | input | 1 | Received byte strobe from the serial engine |
| rx_byte | input | BYTE_W | Received byte |
| tx_valid | output | 1 | One-cycle pulse carrying a byte to send |
| tx_byte | output | BYTE_W | Byte to send |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 12-bit address, which puts the identification bytes at 0xFE0 to 0xFFF, 32-bit data, 8-bit bytes, and registered read data. Registered read data gives every read a fixed one-cycle latency, so a queue of expected read values can be matched against each read in order. The 12-bit window makes the whole identification sequence, its unaligned addresses and the unmapped gap just below it reachable. The stimulus also covers a byte arriving in the very cycle of a consuming read, and in the cycle of a non-consuming read, so both branches of the pending update are exercised.

// File: rtl/ps2_regif_pkg.sv
package ps2_regif_pkg;

   // register selection produced by the address decoder
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_STAT,
      SEL_DATA,
      SEL_DIV,
      SEL_IRQ,
      SEL_ID
   } reg_sel_e;

   // word indices (byte address >> 2)
   localparam int unsigned WIDX_CTRL = 0;
   localparam int unsigned WIDX_STAT = 1;
   localparam int unsigned WIDX_DATA = 2;
   localparam int unsigned WIDX_DIV  = 3;
   localparam int unsigned WIDX_IRQ  = 4;

   // control word enables
   localparam int unsigned CTRL_RXIE = 4;
   localparam int unsigned CTRL_TXIE = 3;

   // status word fields
   localparam int unsigned ST_TXEMPTY = 6;
   localparam int unsigned ST_TXBUSY  = 5;
   localparam int unsigned ST_RXFULL  = 4;
   localparam int unsigned ST_RXBUSY  = 3;
   localparam int unsigned ST_PARITY  = 2;
   localparam int unsigned ST_CLKLINE = 1;
   localparam int unsigned ST_DATLINE = 0;

   // identification window: 8 words at the top of the address space
   localparam int unsigned ID_COUNT = 8;
   localparam int unsigned ID_SPAN  = ID_COUNT * 4;

   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      logic [7:0] b;
      case (idx)
         3'd0:    b = 8'h50;
         3'd1:    b = 8'h10;
         3'd2:    b = 8'h04;
         3'd3:    b = 8'h00;
         3'd4:    b = 8'h0D;
         3'd5:    b = 8'hF0;
         3'd6:    b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/ps2_regif_decode.sv
module ps2_regif_decode
   import ps2_regif_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic [2:0]        id_idx
);

   localparam logic [ADDR_W-1:0] ID_LO = {ADDR_W{1'b1}} - ADDR_W'(ID_SPAN - 1);

   logic [ADDR_W-1:0] widx;
   logic [ADDR_W-1:0] id_off;

   always_comb begin
      widx   = addr >> 2;
      id_off = (addr - ID_LO) >> 2;
      id_idx = id_off[2:0];
   end

   always_comb begin
      sel = SEL_NONE;
      if (addr >= ID_LO) begin
         sel = SEL_ID;
      end else begin
         case (widx)
            ADDR_W'(WIDX_CTRL): sel = SEL_CTRL;
            ADDR_W'(WIDX_STAT): sel = SEL_STAT;
            ADDR_W'(WIDX_DATA): sel = SEL_DATA;
            ADDR_W'(WIDX_DIV):  sel = SEL_DIV;
            ADDR_W'(WIDX_IRQ):  sel = SEL_IRQ;
            default:            sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/ps2_regif_rxbuf.sv
module ps2_regif_rxbuf #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rd_pop,
   output logic              pending,
   output logic [BYTE_W-1:0] last_byte,
   output logic [BYTE_W-1:0] out_byte
);

   logic [BYTE_W-1:0] hold_q;
   logic [BYTE_W-1:0] last_q;
   logic              pend_q;

   // byte a data read returns this cycle
   always_comb out_byte = pend_q ? hold_q : last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
         last_q <= '0;
         pend_q <= 1'b0;
      end else begin
         if (rx_valid) begin
            hold_q <= rx_byte;
         end
         if (rd_pop) begin
            last_q <= out_byte;
         end
         // an arrival in the same cycle as a pop keeps the flag set
         if (rx_valid) begin
            pend_q <= 1'b1;
         end else if (rd_pop) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign pending   = pend_q;
   assign last_byte = last_q;

endmodule

// File: rtl/ps2_regif_rdmux.sv
module ps2_regif_rdmux
   import ps2_regif_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BYTE_W = 8
) (
   input  reg_sel_e          sel,
   input  logic [2:0]        id_idx,
   input  logic [DATA_W-1:0] ctrl,
   input  logic [DATA_W-1:0] div,
   input  logic              pending,
   input  logic [BYTE_W-1:0] last_byte,
   input  logic [BYTE_W-1:0] out_byte,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] irq_word;
   logic              parity;

   always_comb begin
      parity                = ^last_byte;
      stat_word             = '0;
      stat_word[ST_TXEMPTY] = 1'b1;
      stat_word[ST_TXBUSY]  = 1'b0;
      stat_word[ST_RXFULL]  = pending;
      stat_word[ST_RXBUSY]  = 1'b0;
      stat_word[ST_PARITY]  = parity;
      stat_word[ST_CLKLINE] = 1'b0;
      stat_word[ST_DATLINE] = 1'b0;
      irq_word              = '0;
      irq_word[1]           = 1'b1;
      irq_word[0]           = pending;
   end

   always_comb begin
      case (sel)
         SEL_CTRL: rdata = ctrl;
         SEL_STAT: rdata = stat_word;
         SEL_DATA: rdata = DATA_W'(out_byte);
         SEL_DIV:  rdata = div;
         SEL_IRQ:  rdata = irq_word;
         SEL_ID:   rdata = DATA_W'(id_byte(id_idx));
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/ps2_regif.sv
module ps2_regif
   import ps2_regif_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BYTE_W    = 8,
   parameter bit          RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              irq
);

   // elaboration-time parameter checks
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ps2_regif: ADDR_W must cover a 4 KB window");
   end
   if (DATA_W < 8 || DATA_W < BYTE_W) begin : g_bad_data
      $error("ps2_regif: DATA_W must hold a byte and the status word");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("ps2_regif: BYTE_W must be positive");
   end

   reg_sel_e          sel;
   logic [2:0]        id_idx;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] div_q;
   logic              rx_pend;
   logic [BYTE_W-1:0] last_byte;
   logic [BYTE_W-1:0] out_byte;
   logic [DATA_W-1:0] rdata_c;
   logic              rd_pop;
   logic              tx_v_q;
   logic [BYTE_W-1:0] tx_b_q;

   ps2_regif_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr   (bus_addr),
      .sel    (sel),
      .id_idx (id_idx)
   );

   always_comb rd_pop = bus_rd && (sel == SEL_DATA);

   ps2_regif_rxbuf #(.BYTE_W(BYTE_W)) u_rx (
      .clk       (clk),
      .rst       (rst),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .rd_pop    (rd_pop),
      .pending   (rx_pend),
      .last_byte (last_byte),
      .out_byte  (out_byte)
   );

   ps2_regif_rdmux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_mux (
      .sel       (sel),
      .id_idx    (id_idx),
      .ctrl      (ctrl_q),
      .div       (div_q),
      .pending   (rx_pend),
      .last_byte (last_byte),
      .out_byte  (out_byte),
      .rdata     (rdata_c)
   );

   // writable words and transmit pulse
   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
         div_q  <= '0;
         tx_v_q <= 1'b0;
         tx_b_q <= '0;
      end else begin
         tx_v_q <= 1'b0;
         if (bus_wr) begin
            case (sel)
               SEL_CTRL: ctrl_q <= bus_wdata;
               SEL_DIV:  div_q  <= bus_wdata;
               SEL_DATA: begin
                  tx_v_q <= 1'b1;
                  tx_b_q <= bus_wdata[BYTE_W-1:0];
               end
               default: ;
            endcase
         end
      end
   end

   assign tx_valid = tx_v_q;
   assign tx_byte  = tx_b_q;
   assign irq      = (rx_pend & ctrl_q[CTRL_RXIE]) | ctrl_q[CTRL_TXIE];

   // read data stage variant
   if (RDATA_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            rdata_q <= '0;
         end else if (bus_rd) begin
            rdata_q <= rdata_c;
         end
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rdata_c : '0;
   end

endmodule

// File: rtl/ps2_regif_chk.sv
module ps2_regif_chk #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BYTE_W    = 8,
   parameter bit          RDATA_REG = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              rx_valid,
   input logic              tx_valid,
   input logic [BYTE_W-1:0] tx_byte,
   input logic              irq,
   input logic              rx_pend
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] A_ID0  = {ADDR_W{1'b1}} - ADDR_W'(31);

   // R7
   irq_txie_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A_CTRL && bus_wdata[3]) |=> irq);

   // R7
   irq_off_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A_CTRL && !bus_wdata[3] && !bus_wdata[4]) |=> !irq);

   // R9
   tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A_DATA) |=> (tx_valid && tx_byte == $past(bus_wdata[BYTE_W-1:0])));

   // R9
   tx_only_write_chk: assert property (@(posedge clk) disable iff (rst)
      tx_valid |-> $past(bus_wr && bus_addr[ADDR_W-1:2] == A_DATA[ADDR_W-1:2]));

   // R6
   rx_pend_set_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> rx_pend);

   if (RDATA_REG) begin : g_rd_props
      // R3
      stat_txempty_chk: assert property (@(posedge clk) disable iff (rst)
         (bus_rd && bus_addr == A_STAT) |=> (bus_rdata[6] && bus_rdata[4] == $past(rx_pend)));

      // R10
      id_first_chk: assert property (@(posedge clk) disable iff (rst)
         (bus_rd && bus_addr == A_ID0) |=> (bus_rdata == DATA_W'(8'h50)));
   end

endmodule

bind ps2_regif ps2_regif_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .BYTE_W    (BYTE_W),
   .RDATA_REG (RDATA_REG)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .rx_valid  (rx_valid),
   .tx_valid  (tx_valid),
   .tx_byte   (tx_byte),
   .irq       (irq),
   .rx_pend   (rx_pend)
);

// File: tb/ps2_regif_tb.sv
module ps2_regif_tb;

   localparam int unsigned ADDR_W = 12;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned BYTE_W = 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_rd = 1'b0;
   logic              bus_wr = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              rx_valid = 1'b0;
   logic [BYTE_W-1:0] rx_byte = '0;
   logic              tx_valid;
   logic [BYTE_W-1:0] tx_byte;
   logic              irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [DATA_W-1:0] rd_exp_q[$];
   string             rd_tag_q[$];
   logic [BYTE_W-1:0] tx_exp_q[$];

   always #10 clk = ~clk;   // 50 MHz

   ps2_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .RDATA_REG(1'b1)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .tx_valid  (tx_valid),
      .tx_byte   (tx_byte),
      .irq       (irq)
   );

   function automatic void compare(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                                   input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endfunction

   // monitor: reads complete one edge after the strobe, tx pulses last one cycle
   always @(negedge clk) begin
      if (!rst && bus_rd) begin
         if (rd_exp_q.size() == 0) begin
            compare(bus_rdata, '1, "R1 unexpected read");
         end else begin
            compare(bus_rdata, rd_exp_q.pop_front(), rd_tag_q.pop_front());
         end
      end
      if (!rst && tx_valid) begin
         if (tx_exp_q.size() == 0) begin
            compare(DATA_W'(tx_byte), '1, "R11 R9 unexpected tx pulse");
         end else begin
            compare(DATA_W'(tx_byte), DATA_W'(tx_exp_q.pop_front()), "R9 tx byte");
         end
      end
   end

   task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string tag);
      @(negedge clk); #1;
      rd_exp_q.push_back(exp);
      rd_tag_q.push_back(tag);
      bus_addr = a;
      bus_rd   = 1'b1;
      @(negedge clk); #1;
      bus_rd   = 1'b0;
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk); #1;
      if (a == ADDR_W'(8)) tx_exp_q.push_back(d[BYTE_W-1:0]);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk); #1;
      bus_wr    = 1'b0;
   endtask

   task automatic rx_push(input logic [BYTE_W-1:0] b);
      @(negedge clk); #1;
      rx_byte  = b;
      rx_valid = 1'b1;
      @(negedge clk); #1;
      rx_valid = 1'b0;
   endtask

   // data read and byte arrival in the same cycle
   task automatic read_with_rx(input logic [DATA_W-1:0] exp, input logic [BYTE_W-1:0] b, input string tag);
      @(negedge clk); #1;
      rd_exp_q.push_back(exp);
      rd_tag_q.push_back(tag);
      bus_addr = ADDR_W'(8);
      bus_rd   = 1'b1;
      rx_byte  = b;
      rx_valid = 1'b1;
      @(negedge clk); #1;
      bus_rd   = 1'b0;
      rx_valid = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [7:0] id_tab [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      repeat (3) @(negedge clk);
      #1 rst = 1'b0;

      // R12 reset state
      compare(DATA_W'(irq), 0, "R12 irq after reset");
      compare(DATA_W'(tx_valid), 0, "R12 tx_valid after reset");
      compare(bus_rdata, 0, "R12 rdata after reset");
      bus_read(12'h000, 32'h0, "R12 R2 control reset");
      bus_read(12'h004, 32'h40, "R12 R3 status reset");
      bus_read(12'h008, 32'h0, "R12 R5 data reset");
      bus_read(12'h00C, 32'h0, "R12 R2 divisor reset");
      bus_read(12'h010, 32'h2, "R8 irq status reset");

      // R2 full-width registers, R7 transmit enable
      bus_write(12'h000, 32'hDEADBEEF);
      compare(DATA_W'(irq), 1, "R7 tx enable drives irq");
      bus_read(12'h000, 32'hDEADBEEF, "R2 control readback");
      bus_write(12'h00C, 32'h12345678);
      bus_read(12'h00C, 32'h12345678, "R2 divisor readback");
      bus_write(12'h000, 32'h10);
      compare(DATA_W'(irq), 0, "R7 rx enable without pending");

      // R6 R5 R4 receive path
      rx_push(8'hA5);
      compare(DATA_W'(irq), 1, "R7 R6 rx enable with pending");
      bus_read(12'h004, 32'h50, "R3 R4 status pending, old byte parity");
      bus_read(12'h010, 32'h3, "R8 irq status pending");
      bus_read(12'h008, 32'hA5, "R5 pop pending byte");
      compare(DATA_W'(irq), 0, "R7 irq drops after pop");
      bus_read(12'h004, 32'h40, "R4 even parity of A5");
      bus_read(12'h008, 32'hA5, "R5 repeat without pending");
      rx_push(8'h07);
      bus_read(12'h004, 32'h50, "R4 parity ignores waiting byte");
      bus_read(12'h008, 32'h07, "R5 pop 07");
      bus_read(12'h004, 32'h44, "R4 odd parity of 07");

      // R6 arrival in the cycle of a consuming read
      rx_push(8'h11);
      bus_read(12'h004, 32'h54, "R3 pending with parity of 07");
      read_with_rx(32'h11, 8'h22, "R6 pop returns older byte");
      bus_read(12'h004, 32'h50, "R6 still pending after same-cycle arrival");
      bus_read(12'h008, 32'h22, "R6 newer byte kept");
      bus_read(12'h004, 32'h40, "R6 cleared after pop");
      // arrival in the cycle of a non-consuming read
      read_with_rx(32'h22, 8'h01, "R5 R6 repeat while byte arrives");
      bus_read(12'h004, 32'h50, "R6 pending set by arrival");
      bus_read(12'h008, 32'h01, "R6 arrived byte popped");
      bus_read(12'h004, 32'h44, "R4 odd parity of 01");

      // R7 both enables off
      bus_write(12'h000, 32'h0);
      rx_push(8'h33);
      compare(DATA_W'(irq), 0, "R7 pending with enables off");
      bus_read(12'h008, 32'h33, "R5 pop 33");

      // R9 transmit
      bus_write(12'h008, 32'h123456AB);
      bus_write(12'h008, 32'hFFFFFF00);

      // R11 ignored writes, unmapped reads
      bus_write(12'h004, 32'hFFFFFFFF);
      bus_write(12'h010, 32'hFFFFFFFF);
      bus_write(12'h020, 32'hFFFFFFFF);
      bus_write(12'h800, 32'hFFFFFFFF);
      compare(DATA_W'(irq), 0, "R11 ignored writes leave irq");
      bus_read(12'h000, 32'h0, "R11 control untouched");
      bus_read(12'h00C, 32'h12345678, "R11 divisor untouched");
      bus_read(12'h004, 32'h40, "R11 status untouched");
      bus_read(12'h010, 32'h2, "R11 irq status untouched");
      bus_read(12'h014, 32'h0, "R11 unmapped 014");
      bus_read(12'h800, 32'h0, "R11 unmapped 800");
      bus_read(12'hFDC, 32'h0, "R11 unmapped below id window");

      // R10 identification window
      for (int i = 0; i < 8; i++) begin
         bus_read(12'hFE0 + 12'(4 * i), DATA_W'(id_tab[i]), "R10 id byte");
      end
      bus_read(12'hFE2, 32'h50, "R10 unaligned id 0");
      bus_read(12'hFFF, 32'hB1, "R10 unaligned id 7");

      repeat (4) @(negedge clk);
      compare(DATA_W'(tx_exp_q.size()), 0, "R9 all tx pulses seen");
      compare(DATA_W'(rd_exp_q.size()), 0, "R1 all reads returned");
      summary();
   end

endmodule